// File: doc/BRIEF.md
# External Bus Cycle Controller

This block is the master end of a synchronous external memory bus. It takes one read or write request at a time from an internal valid/ready handshake and runs it on the bus as a three-phase cycle. The first phase places the address, the access attributes and the direction on the bus and pulses a transfer-start strobe. The second phase is the data phase: write data is driven, and read data is sampled together with a transfer acknowledge. The third phase holds everything stable. That phase fills the clock that would otherwise sit idle between cycles.

The data phase lasts until an acknowledge is sampled. Each request carries a mode bit. When the bit is set, the controller makes its own acknowledge after a programmed number of extra clocks. When it is clear, the controller waits for the slave's acknowledge pin. A timeout counter ends a data phase that gets no acknowledge and reports an error. Completion goes back to the requester as a one-clock response pulse. For a read, that pulse carries the captured data.

Top module: `ext_bus_master`

## Requirements
- R1: A cycle with no extra wait clocks lasts exactly three clocks: address clock, one data clock, hold clock. Each extra data clock lengthens it by one.
- R2: In the address clock, `bus_ts` is 1 for exactly that one clock. In the same clock, `bus_addr` and `bus_attr` show the request and `bus_rw` shows the direction (1 = read, 0 = write).
- R3: For a read, `rsp_rdata` holds the `bus_din` value that was present on the clock edge where the acknowledge was sampled.
- R4: For a write, `bus_doe` is 0 in the address clock and 1 from the end of the address clock through the end of the hold clock, with `bus_dout` equal to the request data. For reads, `bus_doe` is never 1.
- R5: When `req_int_ack` = 0, the data phase continues while `bus_ta` is sampled 0 and ends on the first edge where it is sampled 1.
- R6: When `req_int_ack` = 1, the data phase lasts `req_wait`+1 clocks (`req_wait` 0 to 15), and `bus_ta` has no effect.
- R7: During the hold clock, `bus_addr`, `bus_attr` and `bus_rw` keep their address-clock values, `bus_ts` is 0, and for writes `bus_dout` keeps the write data.
- R8: `req_ready` is 1 only when idle or in the hold clock. A request presented in the hold clock starts its address clock on the very next clock.
- R9: `rsp_valid` is a one-clock pulse that is visible in the hold clock of each cycle. `rsp_rdata` is 0 for writes.
- R10: With the timeout enabled, a data phase that sees no acknowledge for TO_LIMIT (1024) clocks ends with `rsp_valid` = 1, `rsp_err` = 1 and `rsp_rdata` = 0, and then goes through a normal hold clock.
- R11: If the acknowledge arrives in the last clock of the timeout window, the cycle completes normally with `rsp_err` = 0.
- R12: After reset: `bus_ts` = 0, `bus_doe` = 0, `bus_rw` = 1, `rsp_valid` = 0, `req_ready` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this clock when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Request address |
| req_wdata | input | DW | Write data |
| req_attr | input | ATW | Access attributes |
| req_int_ack | input | 1 | 1 = internal acknowledge, 0 = wait for `bus_ta` |
| req_wait | input | WSW | Extra data clocks before internal acknowledge |
| rsp_valid | output | 1 | Completion pulse |
| rsp_err | output | 1 | Completion by timeout |
| rsp_rdata | output | DW | Captured read data |
| bus_addr | output | AW | Bus address |
| bus_attr | output | ATW | Bus attributes |
| bus_rw | output | 1 | Direction, 1 = read |
| bus_ts | output | 1 | Transfer-start strobe |
| bus_dout | output | DW | Write data to bus |
| bus_doe | output | 1 | Data output enable |
| bus_din | input | DW | Read data from bus |
| bus_ta | input | 1 | Transfer acknowledge from slave |

## Verification
The two functions that can land on the same edge are the expiry of the timeout window and a real acknowledge. The bench drives `bus_ta` exactly in the 1024th data clock, and expects a clean completion with no error and with the data sampled there. It then repeats the cycle with the acknowledge withheld and expects the error completion. In random runs, a new request is also placed in the hold clock of the previous cycle, so that a response pulse and a request acceptance fall in the same clock.

// File: rtl/ebm_pkg.sv
package ebm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2,
    ST_HOLD = 2'd3
  } ebm_state_e;
endpackage

// File: rtl/ebm_wait_gen.sv
module ebm_wait_gen #(
  parameter int WSW = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic           run,
  input  logic [WSW-1:0] load_val,
  output logic           ack_int
);
  logic [WSW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                    cnt_q <= '0;
    else if (load)              cnt_q <= load_val;
    else if (run && cnt_q != 0) cnt_q <= cnt_q - 1'b1;
  end

  assign ack_int = (cnt_q == '0);
endmodule

// File: rtl/ebm_timeout.sv
module ebm_timeout #(
  parameter bit EN    = 1'b1,
  parameter int LIMIT = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic expire
);
  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run)      cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign expire = EN && run && (cnt_q == LAST);
endmodule

// File: rtl/ext_bus_master.sv
module ext_bus_master #(
  parameter int AW       = 32,
  parameter int DW       = 32,
  parameter int ATW      = 4,
  parameter int WSW      = 4,
  parameter bit TO_EN    = 1'b1,
  parameter int TO_LIMIT = 1024
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic           req_write,
  input  logic [AW-1:0]  req_addr,
  input  logic [DW-1:0]  req_wdata,
  input  logic [ATW-1:0] req_attr,
  input  logic           req_int_ack,
  input  logic [WSW-1:0] req_wait,
  output logic           rsp_valid,
  output logic           rsp_err,
  output logic [DW-1:0]  rsp_rdata,
  output logic [AW-1:0]  bus_addr,
  output logic [ATW-1:0] bus_attr,
  output logic           bus_rw,
  output logic           bus_ts,
  output logic [DW-1:0]  bus_dout,
  output logic           bus_doe,
  input  logic [DW-1:0]  bus_din,
  input  logic           bus_ta
);
  import ebm_pkg::*;

  ebm_state_e     state_q;
  logic           int_q;
  logic [WSW-1:0] wait_q;
  logic           ack_int, expire, ack_sel, accept, done, tmo;

  ebm_wait_gen #(.WSW(WSW)) u_wait (
    .clk(clk), .rst(rst),
    .load(state_q == ST_ADDR), .run(state_q == ST_DATA),
    .load_val(wait_q), .ack_int(ack_int)
  );

  ebm_timeout #(.EN(TO_EN), .LIMIT(TO_LIMIT)) u_tmo (
    .clk(clk), .rst(rst), .run(state_q == ST_DATA), .expire(expire)
  );

  assign req_ready = (state_q == ST_IDLE) || (state_q == ST_HOLD);
  assign accept    = req_valid && req_ready;
  assign ack_sel   = int_q ? ack_int : bus_ta;
  assign done      = (state_q == ST_DATA) && ack_sel;
  assign tmo       = (state_q == ST_DATA) && !ack_sel && expire;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      int_q     <= 1'b0;
      wait_q    <= '0;
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
      bus_addr  <= '0;
      bus_attr  <= '0;
      bus_rw    <= 1'b1;
      bus_ts    <= 1'b0;
      bus_dout  <= '0;
      bus_doe   <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      bus_ts    <= 1'b0;
      unique case (state_q)
        ST_IDLE, ST_HOLD: begin
          bus_doe <= 1'b0;
          if (accept) begin
            state_q  <= ST_ADDR;
            bus_ts   <= 1'b1;
            bus_addr <= req_addr;
            bus_attr <= req_attr;
            bus_rw   <= ~req_write;
            bus_dout <= req_write ? req_wdata : '0;
            int_q    <= req_int_ack;
            wait_q   <= req_wait;
          end else begin
            state_q <= ST_IDLE;
            bus_rw  <= 1'b1;
          end
        end
        ST_ADDR: begin
          state_q <= ST_DATA;
          bus_doe <= ~bus_rw;
        end
        ST_DATA: begin
          if (done) begin
            state_q   <= ST_HOLD;
            rsp_valid <= 1'b1;
            rsp_rdata <= bus_rw ? bus_din : '0;
          end else if (tmo) begin
            state_q   <= ST_HOLD;
            rsp_valid <= 1'b1;
            rsp_err   <= 1'b1;
            rsp_rdata <= '0;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ebm_checker.sv
module ebm_checker #(
  parameter int AW  = 32,
  parameter int ATW = 4
) (
  input logic           clk,
  input logic           rst,
  input logic           req_valid,
  input logic           req_ready,
  input logic           rsp_valid,
  input logic           rsp_err,
  input logic [AW-1:0]  bus_addr,
  input logic [ATW-1:0] bus_attr,
  input logic           bus_rw,
  input logic           bus_ts,
  input logic           bus_doe
);
  // R2
  ts_single_chk: assert property (@(posedge clk) disable iff (rst)
    bus_ts |=> !bus_ts);

  // R2
  ts_not_ready_chk: assert property (@(posedge clk) disable iff (rst)
    bus_ts |-> !req_ready);

  // R4
  doe_write_only_chk: assert property (@(posedge clk) disable iff (rst)
    bus_doe |-> !bus_rw);

  // R4
  doe_off_addr_chk: assert property (@(posedge clk) disable iff (rst)
    bus_ts |-> !bus_doe);

  // R7
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> ($stable(bus_addr) && $stable(bus_attr) && $stable(bus_rw)));

  // R8
  no_accept_chk: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && req_ready) |=> !bus_ts);

  // R9
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  // R10
  err_with_rsp_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> rsp_valid);
endmodule

bind ext_bus_master ebm_checker #(.AW(AW), .ATW(ATW)) u_ebm_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_err(rsp_err), .bus_addr(bus_addr),
  .bus_attr(bus_attr), .bus_rw(bus_rw), .bus_ts(bus_ts), .bus_doe(bus_doe)
);

// File: tb/ext_bus_master_bench.sv
module ext_bus_master_bench;
  localparam int AW = 32, DW = 32, ATW = 4, WSW = 4, TO = 1024;

  typedef struct {
    bit          wr;
    bit [AW-1:0] addr;
    bit [DW-1:0] wdata;
    bit [ATW-1:0] attr;
    bit          ia;
    bit [WSW-1:0] ws;
    int          dly;
  } txn_t;

  logic clk = 0, rst = 1;
  logic req_valid = 0, req_write = 0, req_int_ack = 0, bus_ta = 0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0, bus_din = '0;
  logic [ATW-1:0] req_attr = '0;
  logic [WSW-1:0] req_wait = '0;
  logic req_ready, rsp_valid, rsp_err, bus_rw, bus_ts, bus_doe;
  logic [DW-1:0] rsp_rdata, bus_dout;
  logic [AW-1:0] bus_addr;
  logic [ATW-1:0] bus_attr;
  int errors = 0, checks = 0;

  always #5 clk = ~clk;

  ext_bus_master #(.AW(AW), .DW(DW), .ATW(ATW), .WSW(WSW), .TO_EN(1'b1), .TO_LIMIT(TO)) u_ext_bus_master (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_attr(req_attr), .req_int_ack(req_int_ack), .req_wait(req_wait),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .bus_addr(bus_addr), .bus_attr(bus_attr), .bus_rw(bus_rw), .bus_ts(bus_ts),
    .bus_dout(bus_dout), .bus_doe(bus_doe), .bus_din(bus_din), .bus_ta(bus_ta)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_len(txn_t t);
    if (t.ia) return int'(t.ws) + 1;
    return (t.dly >= TO) ? TO : t.dly + 1;
  endfunction

  function automatic bit exp_err(txn_t t);
    return !t.ia && (t.dly >= TO);
  endfunction

  function automatic txn_t rand_txn();
    txn_t t;
    t.wr = 1'($urandom); t.addr = $urandom; t.wdata = $urandom;
    t.attr = 4'($urandom); t.ia = 1'($urandom); t.ws = 4'($urandom);
    t.dly = int'($urandom % 7);
    return t;
  endfunction

  task automatic drive_req(txn_t t);
    req_valid = 1; req_write = t.wr; req_addr = t.addr; req_wdata = t.wdata;
    req_attr = t.attr; req_int_ack = t.ia; req_wait = t.ws;
  endtask

  // Called at the negedge inside the address clock of t.
  task automatic run(txn_t t, bit nxt_en, txn_t n);
    int len = exp_len(t);
    bit [DW-1:0] rd_exp = '0;
    int cyc = 1;
    chk("R2 ts", bus_ts, 1);
    chk("R2 addr", bus_addr, t.addr);
    chk("R2 attr", bus_attr, t.attr);
    chk("R2 rw", bus_rw, !t.wr);
    chk("R4 doe off in address clock", bus_doe, 0);
    chk("R8 ready low in address clock", req_ready, 0);
    req_valid = 1; req_addr = ~t.addr;           // must not be taken
    for (int k = 0; k < len; k++) begin
      @(posedge clk); @(negedge clk); cyc++;
      chk("R2 ts low in data", bus_ts, 0);
      chk("R9 no rsp in data", rsp_valid, 0);
      chk("R8 ready low in data", req_ready, 0);
      chk("R4 doe in data", bus_doe, t.wr);
      if (t.wr) chk("R4 dout", bus_dout, t.wdata);
      bus_din = $urandom;
      if (t.ia) bus_ta = 1'($urandom);            // R6 noise
      else      bus_ta = (k == t.dly);
      if (k == len - 1 && !t.wr && !exp_err(t)) rd_exp = bus_din;
    end
    @(posedge clk); @(negedge clk); cyc++;
    bus_ta = 0;
    chk("R1 cycle length", cyc, len + 2);
    chk(t.ia ? "R6 rsp at count" : "R5 rsp at ack", rsp_valid, 1);
    chk(exp_err(t) ? "R10 err" : "R11 err", rsp_err, exp_err(t));
    chk(t.wr ? "R9 rdata zero" : "R3 rdata", rsp_rdata, exp_err(t) ? 0 : rd_exp);
    chk("R7 addr held", bus_addr, t.addr);
    chk("R7 attr held", bus_attr, t.attr);
    chk("R7 rw held", bus_rw, !t.wr);
    chk("R7 ts low", bus_ts, 0);
    chk("R4 doe in hold", bus_doe, t.wr);
    if (t.wr) chk("R7 dout held", bus_dout, t.wdata);
    chk("R8 ready in hold", req_ready, 1);
    if (nxt_en) drive_req(n); else req_valid = 0;
    @(posedge clk); @(negedge clk);
    if (!nxt_en) begin
      chk("R9 rsp pulse ends", rsp_valid, 0);
      chk("R4 doe off idle", bus_doe, 0);
      chk("R8 idle ts", bus_ts, 0);
    end
  endtask

  task automatic issue(txn_t t);
    @(negedge clk); drive_req(t);
    @(posedge clk); @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    txn_t t, n, d;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    chk("R12 ts", bus_ts, 0); chk("R12 doe", bus_doe, 0); chk("R12 rw", bus_rw, 1);
    chk("R12 rsp", rsp_valid, 0); chk("R12 ready", req_ready, 1);
    d = rand_txn();
    // directed: zero-wait read, external
    t = rand_txn(); t.wr = 0; t.ia = 0; t.dly = 0; issue(t); run(t, 0, d);
    // directed: internal max wait write
    t = rand_txn(); t.wr = 1; t.ia = 1; t.ws = 15; issue(t); run(t, 0, d);
    // directed: ack on final timeout clock (R11), then no ack (R10)
    t = rand_txn(); t.wr = 0; t.ia = 0; t.dly = TO - 1; issue(t); run(t, 0, d);
    t = rand_txn(); t.wr = 0; t.ia = 0; t.dly = TO + 100; issue(t); run(t, 0, d);
    // random, with back-to-back requests in the hold clock (R8)
    t = rand_txn(); issue(t);
    for (int i = 0; i < 40; i++) begin
      bit ch = 1'($urandom);
      n = rand_txn();
      run(t, ch, n);
      if (!ch) issue(n);
      t = n;
    end
    run(t, 0, d);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule